// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between a group of devices and memory and turns 32-bit device virtual addresses into physical addresses. Every device shares one single-level page table held in memory: the table is an array of 32-bit entries, one per 4 KiB page, indexed directly by the page number of a virtual address below 2 GiB. A small fully associative translation cache holds recent entries. On a miss the block fetches the table entry over a one-request-at-a-time memory read port and fills the cache with it.

Software drives the block through a word-addressed register port. Through it, software sets the table base, turns translation on, and drops cached entries whose table-entry byte address falls inside a programmed window. Faults are recorded with the address of the offending table entry and raise a level interrupt through raw, masked and clear status registers.

Top module: `fpt_iommu`

## Requirements
- R1: After reset the enable register (0x04), raw status (0x18), fault-source (0x4C) and fault physical-address (0x50) registers read 0, control bit 10 reads 0, `irq` is low and `xl_req_ready` is high.
- R2: Translation is on only while the enable register holds 0x3. A request made while it does not, or with vaddr bit 31 set (at or above 2 GiB), gets an error response in the cycle after acceptance, sets raw status bit 0, and issues no memory read.
- R3: A cache miss issues exactly one single-cycle memory read at base + 4 × (vaddr >> 12) in the cycle after acceptance. Once the entry returns with bit 0 set, the response follows one cycle later with paddr = {entry[31:12], vaddr[11:0]}.
- R4: A request to a page already cached returns its translation in the cycle after acceptance without any memory read.
- R5: A fetched entry with bit 0 clear yields an error response. It sets raw status bit 1, loads the entry's byte address into the fault-source register (0x4C), and does not fill the cache, so a repeat request reads memory again.
- R6: An error on the memory read response yields an error response, sets raw status bit 2 and loads the entry byte address into the fault physical-address register (0x50). No response within TIMEOUT_CYCLES cycles yields an error response, sets raw status bit 4 and loads the same register.
- R7: The cache holds TLB_ENTRIES translations and replaces them in round-robin order of filling. At most one entry matches any page.
- R8: Writing 1 to control (0x00) bit 10 starts an invalidation. The bit reads 1 and `xl_req_ready` is low until it ends. It ends within TLB_ENTRIES + 2 cycles once no walk is in flight. It drops exactly the entries whose byte address base + 4 × page lies between range start (0x0C) and range end (0x10), both inclusive.
- R9: Masked status (0x1C) equals raw status AND NOT mask (0x14). `irq` is the OR of the masked bits. Writing to clear (0x20) clears each raw bit written as 1, and 0xFF clears all.
- R10: The base (0x08), range start, range end and mask registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Translation request accepted when high with valid |
| xl_req_vaddr | input | 32 | Virtual address to translate |
| xl_rsp_valid | output | 1 | Translation response valid, one cycle |
| xl_rsp_err | output | 1 | Response carries a fault |
| xl_rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| pt_rd_req | output | 1 | Table entry read request, one cycle |
| pt_rd_addr | output | 32 | Byte address of the table entry to read |
| pt_rd_valid | input | 1 | Table entry read data valid |
| pt_rd_err | input | 1 | Table entry read returned an error |
| pt_rd_data | input | 32 | Table entry read data |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
The bench builds the block with TLB_ENTRIES = 4 and TIMEOUT_CYCLES = 16. Four entries let five distinct pages force the round-robin pointer to wrap and evict the oldest fill within a handful of requests. The short timeout lets a dropped memory read turn into a timeout fault after a brief wait. A window covering two of four cached pages, with the memory mapping changed in between, shows at the ports both which entries were dropped and that the range bounds are inclusive.

// File: rtl/fpt_pkg.sv
`timescale 1ns/1ps
package fpt_pkg;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned VA_BITS    = 31;
  localparam int unsigned VPN_W      = VA_BITS - PAGE_SHIFT;
  localparam int unsigned PPN_W      = 32 - PAGE_SHIFT;
  localparam int unsigned RA_W       = 7;
  localparam int unsigned NSTAT      = 6;
  localparam int unsigned INV_BIT    = 10;
  localparam int unsigned ST_CFG     = 0;
  localparam int unsigned ST_PTE     = 1;
  localparam int unsigned ST_BERR    = 2;
  localparam int unsigned ST_TMO     = 4;

  localparam logic [RA_W-1:0] OFS_CTRL   = 7'h00;
  localparam logic [RA_W-1:0] OFS_ENA    = 7'h04;
  localparam logic [RA_W-1:0] OFS_BASE   = 7'h08;
  localparam logic [RA_W-1:0] OFS_RSTART = 7'h0C;
  localparam logic [RA_W-1:0] OFS_REND   = 7'h10;
  localparam logic [RA_W-1:0] OFS_MASK   = 7'h14;
  localparam logic [RA_W-1:0] OFS_RAW    = 7'h18;
  localparam logic [RA_W-1:0] OFS_MSKD   = 7'h1C;
  localparam logic [RA_W-1:0] OFS_CLR    = 7'h20;
  localparam logic [RA_W-1:0] OFS_SRC    = 7'h4C;
  localparam logic [RA_W-1:0] OFS_FPA    = 7'h50;

  typedef enum logic [1:0] {CS_IDLE, CS_WALK, CS_INV} ctl_state_e;
endpackage

// File: rtl/fpt_regs.sv
`timescale 1ns/1ps
module fpt_regs
  import fpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NSTAT-1:0] ev_set,
  input  logic             src_ld,
  input  logic             pa_ld,
  input  logic [31:0]      fault_addr,
  input  logic             inv_done,
  output logic             enabled,
  output logic [31:0]      base,
  output logic [31:0]      rng_start,
  output logic [31:0]      rng_end,
  output logic             inv_pend,
  output logic             irq
);
  logic [1:0]       ena_q, ena_d;
  logic [31:0]      base_q, base_d, rs_q, rs_d, re_q, re_d;
  logic [31:0]      src_q, src_d, fpa_q, fpa_d;
  logic [NSTAT-1:0] mask_q, mask_d, raw_q, raw_d;
  logic             inv_q, inv_d;

  always_comb begin
    ena_d = ena_q; base_d = base_q; rs_d = rs_q; re_d = re_q;
    mask_d = mask_q; src_d = src_q; fpa_d = fpa_q;
    raw_d = raw_q; inv_d = inv_q;
    if (inv_done) inv_d = 1'b0;
    if (wr_en) begin
      case (addr)
        OFS_CTRL:   if (wdata[INV_BIT]) inv_d = 1'b1;
        OFS_ENA:    ena_d  = wdata[1:0];
        OFS_BASE:   base_d = wdata;
        OFS_RSTART: rs_d   = wdata;
        OFS_REND:   re_d   = wdata;
        OFS_MASK:   mask_d = wdata[NSTAT-1:0];
        OFS_CLR:    raw_d  = raw_q & ~wdata[NSTAT-1:0];
        default: ;
      endcase
    end
    raw_d = raw_d | ev_set;
    if (src_ld) src_d = fault_addr;
    if (pa_ld)  fpa_d = fault_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0; base_q <= '0; rs_q <= '0; re_q <= '0;
      mask_q <= '0; raw_q <= '0; src_q <= '0; fpa_q <= '0; inv_q <= 1'b0;
    end else begin
      ena_q <= ena_d; base_q <= base_d; rs_q <= rs_d; re_q <= re_d;
      mask_q <= mask_d; raw_q <= raw_d; src_q <= src_d; fpa_q <= fpa_d;
      inv_q <= inv_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL:   rdata[INV_BIT] = inv_q;
      OFS_ENA:    rdata[1:0] = ena_q;
      OFS_BASE:   rdata = base_q;
      OFS_RSTART: rdata = rs_q;
      OFS_REND:   rdata = re_q;
      OFS_MASK:   rdata[NSTAT-1:0] = mask_q;
      OFS_RAW:    rdata[NSTAT-1:0] = raw_q;
      OFS_MSKD:   rdata[NSTAT-1:0] = raw_q & ~mask_q;
      OFS_SRC:    rdata = src_q;
      OFS_FPA:    rdata = fpa_q;
      default: ;
    endcase
  end

  assign enabled   = (ena_q == 2'b11);
  assign base      = base_q;
  assign rng_start = rs_q;
  assign rng_end   = re_q;
  assign inv_pend  = inv_q;
  assign irq       = |(raw_q & ~mask_q);

  // R9: a full clear with no new event empties the raw status
  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CLR && wdata[NSTAT-1:0] == '1 && ev_set == '0) |=> (raw_q == '0));
  // R8: the busy flag only drops through a completed scan
  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_q && !inv_done) |=> inv_q);
endmodule

// File: rtl/fpt_tlb.sv
`timescale 1ns/1ps
module fpt_tlb
  import fpt_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [31:0]      base,
  input  logic [31:0]      rng_start,
  input  logic [31:0]      rng_end
);
  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_d [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_d [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;
  logic [31:0]        sel_ea;
  logic               sel_in;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
  end
  assign hit = |hit_vec;

  // one shared range comparator, stepped across the entries by the scan index
  assign sel_ea = base + 32'({vpn_q[inv_idx], 2'b00});
  assign sel_in = (sel_ea >= rng_start) && (sel_ea <= rng_end);

  always_comb begin
    vld_d = vld_q; vpn_d = vpn_q; ppn_d = ppn_q; rr_d = rr_q;
    if (fill_en) begin
      vld_d[rr_q] = 1'b1;
      vpn_d[rr_q] = fill_vpn;
      ppn_d[rr_q] = fill_ppn;
      rr_d = (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
    if (inv_en && sel_in) vld_d[inv_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0; rr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0; ppn_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_d; rr_q <= rr_d;
      if (fill_en) begin
        vpn_q <= vpn_d; ppn_q <= ppn_d;
      end
    end
  end

  // R7: no page is ever cached twice
  assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8: a scan never overlaps a fill
  assert_scan_fill_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && inv_en));
endmodule

// File: rtl/fpt_ctrl.sv
`timescale 1ns/1ps
module fpt_ctrl
  import fpt_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TMO     = 64,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned TMO_W = $clog2(TMO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_paddr,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_valid,
  input  logic             mem_err,
  input  logic [31:0]      mem_data,
  input  logic             enabled,
  input  logic [31:0]      base,
  input  logic             inv_pend,
  output logic             inv_done,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             inv_en,
  output logic [IDX_W-1:0] inv_idx,
  output logic [NSTAT-1:0] ev_set,
  output logic             src_ld,
  output logic             pa_ld,
  output logic [31:0]      fault_addr
);
  ctl_state_e            st_q, st_d;
  logic [VPN_W-1:0]      vpn_q, vpn_d;
  logic [PAGE_SHIFT-1:0] off_q, off_d;
  logic [31:0]           ea_q, ea_d, rspa_q, rspa_d;
  logic [TMO_W-1:0]      tmo_q, tmo_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  rspv_q, rspv_d, rspe_q, rspe_d, mreq_q, mreq_d;
  logic                  acc, in_rng;
  logic                  unused_bits;

  assign unused_bits = ^mem_data[PAGE_SHIFT-1:1];
  assign req_ready = (st_q == CS_IDLE) && !inv_pend;
  assign acc       = req_valid && req_ready;
  assign in_rng    = !req_vaddr[31];
  assign lk_vpn    = req_vaddr[VA_BITS-1:PAGE_SHIFT];
  assign fill_vpn  = vpn_q;
  assign fill_ppn  = mem_data[31:PAGE_SHIFT];
  assign inv_idx   = idx_q;
  assign fault_addr = ea_q;

  always_comb begin
    st_d = st_q; vpn_d = vpn_q; off_d = off_q; ea_d = ea_q; tmo_d = tmo_q;
    idx_d = idx_q; rspa_d = rspa_q;
    rspv_d = 1'b0; rspe_d = 1'b0; mreq_d = 1'b0;
    fill_en = 1'b0; inv_en = 1'b0; inv_done = 1'b0;
    ev_set = '0; src_ld = 1'b0; pa_ld = 1'b0;
    case (st_q)
      CS_IDLE: begin
        if (inv_pend) begin
          st_d = CS_INV; idx_d = '0;
        end else if (acc) begin
          if (!enabled || !in_rng) begin
            rspv_d = 1'b1; rspe_d = 1'b1; rspa_d = '0; ev_set[ST_CFG] = 1'b1;
          end else if (hit) begin
            rspv_d = 1'b1; rspa_d = {hit_ppn, req_vaddr[PAGE_SHIFT-1:0]};
          end else begin
            mreq_d = 1'b1; st_d = CS_WALK; tmo_d = '0;
            vpn_d = lk_vpn; off_d = req_vaddr[PAGE_SHIFT-1:0];
            ea_d = base + 32'({lk_vpn, 2'b00});
          end
        end
      end
      CS_WALK: begin
        if (mem_valid) begin
          st_d = CS_IDLE; rspv_d = 1'b1;
          if (mem_err) begin
            rspe_d = 1'b1; rspa_d = '0; ev_set[ST_BERR] = 1'b1; pa_ld = 1'b1;
          end else if (!mem_data[0]) begin
            rspe_d = 1'b1; rspa_d = '0; ev_set[ST_PTE] = 1'b1; src_ld = 1'b1;
          end else begin
            fill_en = 1'b1; rspa_d = {mem_data[31:PAGE_SHIFT], off_q};
          end
        end else if (tmo_q == TMO_W'(TMO - 1)) begin
          st_d = CS_IDLE; rspv_d = 1'b1; rspe_d = 1'b1; rspa_d = '0;
          ev_set[ST_TMO] = 1'b1; pa_ld = 1'b1;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      CS_INV: begin
        inv_en = 1'b1;
        if (idx_q == IDX_W'(ENTRIES - 1)) begin
          st_d = CS_IDLE; inv_done = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_IDLE; vpn_q <= '0; off_q <= '0; ea_q <= '0; tmo_q <= '0;
      idx_q <= '0; rspa_q <= '0; rspv_q <= 1'b0; rspe_q <= 1'b0; mreq_q <= 1'b0;
    end else begin
      st_q <= st_d; tmo_q <= tmo_d; idx_q <= idx_d;
      rspv_q <= rspv_d; rspe_q <= rspe_d; mreq_q <= mreq_d;
      if (rspv_d) rspa_q <= rspa_d;
      if (mreq_d) begin
        vpn_q <= vpn_d; off_q <= off_d; ea_q <= ea_d;
      end
    end
  end

  assign rsp_valid = rspv_q;
  assign rsp_err   = rspe_q;
  assign rsp_paddr = rspa_q;
  assign mem_req   = mreq_q;
  assign mem_addr  = ea_q;

  // R8: requests are held off while an invalidation is pending
  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pend |-> !req_ready);
  // R3: a table read request lasts one cycle
  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R4: a cached page answers in the next cycle without fault
  assert_hit_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && enabled && in_rng && hit) |=> (rsp_valid && !rsp_err && !mem_req));
  // R2: a disabled unit refuses at once
  assert_disabled_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !enabled) |=> (rsp_valid && rsp_err && !mem_req));
endmodule

// File: rtl/fpt_iommu.sv
`timescale 1ns/1ps
module fpt_iommu
  import fpt_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES    = 8,
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        xl_req_valid,
  output logic        xl_req_ready,
  input  logic [31:0] xl_req_vaddr,
  output logic        xl_rsp_valid,
  output logic        xl_rsp_err,
  output logic [31:0] xl_rsp_paddr,
  output logic        pt_rd_req,
  output logic [31:0] pt_rd_addr,
  input  logic        pt_rd_valid,
  input  logic        pt_rd_err,
  input  logic [31:0] pt_rd_data,
  output logic        irq
);
  localparam int unsigned IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

  logic [NSTAT-1:0] ev_set;
  logic             src_ld, pa_ld, inv_done, enabled, inv_pend;
  logic [31:0]      fault_addr, base, rng_start, rng_end;
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [PPN_W-1:0] hit_ppn, fill_ppn;
  logic             hit, fill_en, inv_en;
  logic [IDX_W-1:0] inv_idx;

  fpt_regs u_regs (
    .clk, .rst_n, .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ev_set, .src_ld, .pa_ld, .fault_addr, .inv_done,
    .enabled, .base, .rng_start, .rng_end, .inv_pend, .irq
  );

  fpt_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk, .rst_n, .lk_vpn, .hit, .hit_ppn, .fill_en, .fill_vpn, .fill_ppn,
    .inv_en, .inv_idx, .base, .rng_start, .rng_end
  );

  fpt_ctrl #(.ENTRIES(TLB_ENTRIES), .TMO(TIMEOUT_CYCLES)) u_ctrl (
    .clk, .rst_n, .req_valid(xl_req_valid), .req_vaddr(xl_req_vaddr),
    .req_ready(xl_req_ready), .rsp_valid(xl_rsp_valid), .rsp_err(xl_rsp_err),
    .rsp_paddr(xl_rsp_paddr), .mem_req(pt_rd_req), .mem_addr(pt_rd_addr),
    .mem_valid(pt_rd_valid), .mem_err(pt_rd_err), .mem_data(pt_rd_data),
    .enabled, .base, .inv_pend, .inv_done, .lk_vpn, .hit, .hit_ppn,
    .fill_en, .fill_vpn, .fill_ppn, .inv_en, .inv_idx, .ev_set, .src_ld,
    .pa_ld, .fault_addr
  );
endmodule

// File: tb/fpt_iommu_tb_top.sv
`timescale 1ns/1ps
module fpt_iommu_tb_top;
  import fpt_pkg::*;
  localparam int NENT = 4;
  localparam int TMO  = 16;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int MOFF0 = 32'h40000;
  localparam int MOFF1 = 32'h50000;
  localparam int BAD_VPN = 32'h77;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr_en;
  logic [6:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic xl_req_valid, xl_req_ready, xl_rsp_valid, xl_rsp_err;
  logic [31:0] xl_req_vaddr, xl_rsp_paddr;
  logic pt_rd_req, pt_rd_valid, pt_rd_err, irq;
  logic [31:0] pt_rd_addr, pt_rd_data;

  always #5 clk = ~clk;

  fpt_iommu #(.TLB_ENTRIES(NENT), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata,
    .xl_req_valid, .xl_req_ready, .xl_req_vaddr, .xl_rsp_valid, .xl_rsp_err,
    .xl_rsp_paddr, .pt_rd_req, .pt_rd_addr, .pt_rd_valid, .pt_rd_err,
    .pt_rd_data, .irq
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int map_off = MOFF0;
  int mem_mode = 0;   // 0 normal, 1 error response, 2 no response
  int mem_reads = 0;
  int mw_cnt = 0;
  logic [31:0] mem_last = '0;
  logic [31:0] mw_addr = '0;

  bit          exp_err_q[$];
  logic [31:0] exp_pa_q[$];
  int          exp_lat_q[$];
  string       exp_tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] pa_of(int vpn, int off, int moff);
    return (32'(vpn + moff) << 12) | 32'(off);
  endfunction

  function automatic logic [31:0] pte_of(logic [31:0] a);
    int pg;
    pg = int'((a - BASE) >> 2);
    if (pg == BAD_VPN) return 32'h0000_3000;
    return (32'(pg + map_off) << 12) | 32'h1;
  endfunction

  // table memory model
  always @(negedge clk) begin
    pt_rd_valid = 1'b0;
    pt_rd_err = 1'b0;
    if (mw_cnt > 0) begin
      mw_cnt--;
      if (mw_cnt == 0) begin
        pt_rd_valid = 1'b1;
        pt_rd_data = pte_of(mw_addr);
        pt_rd_err = (mem_mode == 1);
      end
    end
    if (rst_n && pt_rd_req) begin
      mem_reads++;
      mem_last = pt_rd_addr;
      mw_addr = pt_rd_addr;
      if (mem_mode != 2) mw_cnt = 2;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && xl_rsp_valid) begin
      if (exp_err_q.size() == 0) begin
        chk(1'b0, "R3 unexpected response", xl_rsp_paddr, 32'h0);
      end else begin
        bit e; logic [31:0] p; int l; string t;
        e = exp_err_q.pop_front(); p = exp_pa_q.pop_front();
        l = exp_lat_q.pop_front(); t = exp_tag_q.pop_front();
        chk(xl_rsp_err == e, {t, " err"}, 32'(xl_rsp_err), 32'(e));
        chk(xl_rsp_paddr == p, {t, " paddr"}, xl_rsp_paddr, p);
        if (l >= 0) chk((cyc - acc_cyc) == l, {t, " latency"}, 32'(cyc - acc_cyc), 32'(l));
      end
    end
  end

  // watchdog
  initial begin
    while (cyc < 50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
    finish_run();
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // driver: pushes the expected response and issues the request
  task automatic xl(input logic [31:0] va, input bit e, input logic [31:0] pa, input int lat, input string tag);
    @(negedge clk);
    while (!xl_req_ready) @(negedge clk);
    exp_err_q.push_back(e); exp_pa_q.push_back(pa);
    exp_lat_q.push_back(lat); exp_tag_q.push_back(tag);
    acc_cyc = cyc + 1;
    xl_req_valid = 1'b1; xl_req_vaddr = va;
    @(negedge clk);
    xl_req_valid = 1'b0;
    while (exp_err_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int r0;
    int polls;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    xl_req_valid = 1'b0; xl_req_vaddr = '0;
    pt_rd_valid = 1'b0; pt_rd_err = 1'b0; pt_rd_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(OFS_ENA, d);  chk(d == 0, "R1 enable", d, 0);
    rd(OFS_RAW, d);  chk(d == 0, "R1 raw status", d, 0);
    rd(OFS_SRC, d);  chk(d == 0, "R1 fault source", d, 0);
    rd(OFS_FPA, d);  chk(d == 0, "R1 fault paddr", d, 0);
    rd(OFS_CTRL, d); chk(d[10] == 0, "R1 busy bit", d, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(xl_req_ready == 1, "R1 ready", 32'(xl_req_ready), 1);

    // R2 disabled
    r0 = mem_reads;
    xl(32'h0000_5123, 1'b1, 32'h0, 0, "R2 disabled");
    rd(OFS_RAW, d); chk(d == 32'h1, "R2 cfg status bit0", d, 32'h1);
    chk(mem_reads == r0, "R2 no read", 32'(mem_reads), 32'(r0));
    wr(OFS_ENA, 32'h1);
    xl(32'h0000_5123, 1'b1, 32'h0, 0, "R2 enable=1 still off");
    wr(OFS_CLR, 32'hFF);
    rd(OFS_RAW, d); chk(d == 0, "R9 clear all", d, 0);

    // R10 readback and setup
    wr(OFS_BASE, BASE);
    wr(OFS_MASK, 32'h2A);
    rd(OFS_BASE, d); chk(d == BASE, "R10 base", d, BASE);
    rd(OFS_MASK, d); chk(d == 32'h2A, "R10 mask", d, 32'h2A);
    wr(OFS_MASK, 32'h0);
    wr(OFS_ENA, 32'h3);

    // R3 miss
    r0 = mem_reads;
    xl(32'h0000_5123, 1'b0, pa_of(5, 'h123, MOFF0), -1, "R3 miss");
    chk(mem_reads == r0 + 1, "R3 one read", 32'(mem_reads), 32'(r0 + 1));
    chk(mem_last == BASE + 32'd20, "R3 entry addr", mem_last, BASE + 32'd20);

    // R4 hit
    r0 = mem_reads;
    xl(32'h0000_5ABC, 1'b0, pa_of(5, 'hABC, MOFF0), 0, "R4 hit");
    chk(mem_reads == r0, "R4 no read", 32'(mem_reads), 32'(r0));

    // R2 out of range
    xl(32'h8000_0000, 1'b1, 32'h0, 0, "R2 beyond 2GiB");
    rd(OFS_RAW, d); chk(d[0] == 1, "R2 range status bit0", d, 1);
    wr(OFS_CLR, 32'h01);

    // R5 invalid entry
    r0 = mem_reads;
    xl(32'h0007_7010, 1'b1, 32'h0, -1, "R5 invalid entry");
    rd(OFS_RAW, d); chk(d == 32'h2, "R5 status bit1", d, 32'h2);
    rd(OFS_SRC, d); chk(d == BASE + 32'h1DC, "R5 fault source", d, BASE + 32'h1DC);
    chk(irq == 1, "R9 irq raised", 32'(irq), 1);
    xl(32'h0007_7010, 1'b1, 32'h0, -1, "R5 repeat");
    chk(mem_reads == r0 + 2, "R5 no fill", 32'(mem_reads), 32'(r0 + 2));
    wr(OFS_MASK, 32'h3F);
    rd(OFS_MSKD, d); chk(d == 0, "R9 masked status", d, 0);
    chk(irq == 0, "R9 irq masked", 32'(irq), 0);
    rd(OFS_RAW, d); chk(d == 32'h2, "R9 raw kept under mask", d, 32'h2);
    wr(OFS_MASK, 32'h0);
    wr(OFS_CLR, 32'hFF);
    chk(irq == 0, "R9 irq after clear", 32'(irq), 0);

    // R6 memory error and timeout
    mem_mode = 1;
    xl(32'h0001_0000, 1'b1, 32'h0, -1, "R6 bus error");
    rd(OFS_RAW, d); chk(d == 32'h4, "R6 status bit2", d, 32'h4);
    rd(OFS_FPA, d); chk(d == BASE + 32'h40, "R6 fault paddr", d, BASE + 32'h40);
    wr(OFS_CLR, 32'hFF);
    mem_mode = 2;
    xl(32'h0001_1000, 1'b1, 32'h0, -1, "R6 timeout");
    rd(OFS_RAW, d); chk(d == 32'h10, "R6 status bit4", d, 32'h10);
    rd(OFS_FPA, d); chk(d == BASE + 32'h44, "R6 timeout paddr", d, BASE + 32'h44);
    wr(OFS_CLR, 32'hFF);
    mem_mode = 0;

    // R7 round robin: slot0 holds page 5
    xl(32'h0000_1000, 1'b0, pa_of(1, 0, MOFF0), -1, "R7 fill 1");
    xl(32'h0000_2000, 1'b0, pa_of(2, 0, MOFF0), -1, "R7 fill 2");
    xl(32'h0000_3000, 1'b0, pa_of(3, 0, MOFF0), -1, "R7 fill 3");
    r0 = mem_reads;
    xl(32'h0000_5004, 1'b0, pa_of(5, 4, MOFF0), 0, "R7 hit 5");
    xl(32'h0000_1004, 1'b0, pa_of(1, 4, MOFF0), 0, "R7 hit 1");
    chk(mem_reads == r0, "R7 all four cached", 32'(mem_reads), 32'(r0));
    xl(32'h0000_4000, 1'b0, pa_of(4, 0, MOFF0), -1, "R7 fill 4 evicts 5");
    r0 = mem_reads;
    xl(32'h0000_5008, 1'b0, pa_of(5, 8, MOFF0), -1, "R7 page 5 evicted");
    chk(mem_reads == r0 + 1, "R7 oldest replaced", 32'(mem_reads), 32'(r0 + 1));
    r0 = mem_reads;
    xl(32'h0000_3008, 1'b0, pa_of(3, 8, MOFF0), 0, "R7 page 3 kept");
    chk(mem_reads == r0, "R7 no read for 3", 32'(mem_reads), 32'(r0));

    // R8 range invalidation over pages 3 and 4, inclusive bounds
    map_off = MOFF1;
    wr(OFS_RSTART, BASE + 32'd12);
    wr(OFS_REND, BASE + 32'd16);
    rd(OFS_REND, d); chk(d == BASE + 32'd16, "R10 range end", d, BASE + 32'd16);
    wr(OFS_CTRL, 32'h400);
    rd(OFS_CTRL, d); chk(d[10] == 1, "R8 busy reads 1", d, 32'h400);
    chk(xl_req_ready == 0, "R8 requests held", 32'(xl_req_ready), 0);
    polls = 0;
    while (d[10] && polls < NENT + 4) begin
      rd(OFS_CTRL, d);
      polls++;
    end
    chk(polls <= NENT + 2, "R8 completion time", 32'(polls), 32'(NENT + 2));
    r0 = mem_reads;
    xl(32'h0000_2010, 1'b0, pa_of(2, 'h10, MOFF0), 0, "R8 page 2 kept");
    xl(32'h0000_5010, 1'b0, pa_of(5, 'h10, MOFF0), 0, "R8 page 5 kept");
    chk(mem_reads == r0, "R8 outside range untouched", 32'(mem_reads), 32'(r0));
    xl(32'h0000_3010, 1'b0, pa_of(3, 'h10, MOFF1), -1, "R8 start bound dropped");
    xl(32'h0000_4010, 1'b0, pa_of(4, 'h10, MOFF1), -1, "R8 end bound dropped");
    chk(mem_reads == r0 + 2, "R8 refetch count", 32'(mem_reads), 32'(r0 + 2));

    repeat (3) @(negedge clk);
    chk(exp_err_q.size() == 0, "R3 responses outstanding", 32'(exp_err_q.size()), 0);
    finish_run();
  end
endmodule